// File: doc/BRIEF.md
# Pipeline Control with Travelling Control Words

This block is the control half of a five-stage in-order integer pipeline: fetch, decode with register read, execute, memory access and write-back. It holds the program counter and the fetched instruction register. It decodes each 32-bit instruction once, in the decode stage. The decoded control word then moves down the pipeline one stage register at a time, together with a valid bit. At every stage, the fields that stage has used are dropped from the word it passes on. The datapath (ALU, register file, memories, forwarding) sits outside the block. It takes its enables and selects from this block and returns only an execute-stage equality flag.

Every instruction that writes a register does so in stage five. ALU results therefore spend the memory stage being copied into the memory-stage result register. Conditional branches are predicted not taken and resolve in execute. The instruction right behind a taken branch is an architectural delay slot and completes. The next sequential instruction is already being fetched when the branch resolves. It enters decode with its valid bit cleared, and every enable it would drive later is held low.

Top module: `dstat_pipe_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the PC at zero and empties the pipeline. In the first cycle after reset, ex_valid_o, pc_take_o, mem_read_o, mem_write_o, mem_pass_o and wb_en_o are all low.
- R2: pc_o advances by 4 every cycle unless pc_take_o is high. pc_take_o is high, in the same cycle as eq_i, exactly when a valid branch-equal (opcode bits 31:26 = 000100) is in execute. The next pc_o is then the branch's own address + 4 + (sign-extended bits 15:0 shifted left by 2).
- R3: An instruction fetched in cycle n that writes a register raises wb_en_o in cycle n+4. For opcode 000000 the destination on wb_dst_o is bits 15:11. For load, add-immediate and or-immediate it is bits 20:16.
- R4: A store (opcode 101011) raises mem_write_o in cycle n+3 and never raises wb_en_o.
- R5: A load (opcode 100011) raises mem_read_o in cycle n+3 and wb_en_o in cycle n+4.
- R6: An instruction that writes a register from the ALU raises mem_pass_o in its memory-stage cycle n+3 and does not access data memory.
- R7: In execute (cycle n+2), ex_alu_op_o is 0 for add/add-immediate/load/store, 1 for subtract and branch, 2 for AND and 3 for OR/or-immediate. ex_imm_sel_o is high for add-immediate (001000), or-immediate (001101), load and store. ex_imm_zext_o is high only for or-immediate. ex_ovf_en_o is high only for add, subtract and add-immediate. Under opcode 000000 with bits 10:6 zero, function bits 5:0 of 100000, 100010, 100100 and 100101 select add, subtract, AND and OR.
- R8: After a taken branch, the instruction directly behind it (the delay slot) completes normally. The instruction fetched in the cycle of pc_take_o is squashed: ex_valid_o is low for it, and it never raises ex_ovf_en_o, mem_read_o, mem_write_o, mem_pass_o or wb_en_o.
- R9: A branch, an unknown opcode, an unknown function code, and an opcode-000000 word with nonzero bits 10:6 raise no memory enable and no write-back.
- R10: While an instruction sits in decode (cycle n+1), rf_rs_o and rf_rt_o carry its bits 25:21 and 20:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word read at pc_o |
| eq_i | input | 1 | Operands of the execute-stage instruction are equal |
| pc_o | output | PC_W | Current fetch address |
| pc_take_o | output | 1 | Taken branch in execute; PC loads the target |
| rf_rs_o | output | 5 | First register-read address, decode stage |
| rf_rt_o | output | 5 | Second register-read address, decode stage |
| ex_valid_o | output | 1 | Execute stage holds a live instruction |
| ex_alu_op_o | output | 2 | ALU operation select |
| ex_imm_sel_o | output | 1 | Second ALU operand is the immediate |
| ex_imm_zext_o | output | 1 | Immediate is zero-extended rather than sign-extended |
| ex_ovf_en_o | output | 1 | Overflow detection enabled |
| mem_read_o | output | 1 | Data-memory read |
| mem_write_o | output | 1 | Data-memory write |
| mem_pass_o | output | 1 | Copy the ALU result into the memory-stage result register |
| wb_en_o | output | 1 | Register-file write enable |
| wb_dst_o | output | 5 | Register-file write address |

## Verification
Take n as the cycle in which an instruction's address is on pc_o. Its read addresses are due at n+1, its execute controls at n+2, its memory enables at n+3 and its write-back at n+4. pc_take_o depends on eq_i in the same cycle, and the redirected pc_o appears one cycle later. The bench keeps its own four-entry model of which word sits in which stage, marking squashed slots, and advances it once per cycle. Outputs are compared shortly after the falling edge, once eq_i has been driven and before the model shifts. Each stage's expectations therefore come from the model entry that occupies that stage in that cycle.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_AW  = 5;
  localparam int IMM_W   = 16;
  localparam int OP_W    = 6;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_e;

  localparam logic [OP_W-1:0] OP_RR    = 6'h00;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OP_ADDI  = 6'h08;
  localparam logic [OP_W-1:0] OP_ORI   = 6'h0D;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  // fields consumed in execute
  typedef struct packed {
    alu_op_e alu_op;
    logic    imm_sel;
    logic    imm_zext;
    logic    ovf_en;
    logic    branch;
  } ex_ctl_t;

  // fields consumed in memory access
  typedef struct packed {
    logic rd;
    logic wr;
  } mem_ctl_t;

  // fields consumed in write-back
  typedef struct packed {
    logic              en;
    logic [REG_AW-1:0] dst;
  } wb_ctl_t;

  // bundle shrinks as it moves: each stage keeps only what lies ahead
  typedef struct packed {
    logic     valid;
    ex_ctl_t  ex;
    mem_ctl_t mem;
    wb_ctl_t  wb;
  } ex_bundle_t;

  typedef struct packed {
    logic     valid;
    mem_ctl_t mem;
    wb_ctl_t  wb;
  } mem_bundle_t;

  typedef struct packed {
    logic    valid;
    wb_ctl_t wb;
  } wb_bundle_t;
endpackage

// File: rtl/pcc_fetch.sv
module pcc_fetch
  import pcc_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               take_i,
  input  logic [PC_W-1:0]    target_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [INSTR_W-1:0] ir_o,
  output logic [PC_W-1:0]    dpc_o,
  output logic               dvalid_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [PC_W-1:0]    pc_q;
  logic [INSTR_W-1:0] ir_q;
  logic [PC_W-1:0]    dpc_q;
  logic               dvalid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= RESET_PC;
      ir_q     <= '0;
      dpc_q    <= '0;
      dvalid_q <= 1'b0;
    end else begin
      ir_q     <= instr_i;
      dpc_q    <= pc_q;
      // word fetched while a taken branch resolves is the wrong path
      dvalid_q <= ~take_i;
      pc_q     <= take_i ? target_i : pc_q + STEP;
    end
  end

  assign pc_o     = pc_q;
  assign ir_o     = ir_q;
  assign dpc_o    = dpc_q;
  assign dvalid_o = dvalid_q;
endmodule

// File: rtl/pcc_decode.sv
module pcc_decode
  import pcc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [INSTR_W-1:0] ir_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic               valid_i,
  output ex_bundle_t         bundle_o,
  output logic [PC_W-1:0]    target_o,
  output logic [REG_AW-1:0]  rs_o,
  output logic [REG_AW-1:0]  rt_o
);
  localparam int SEXT_W = PC_W - IMM_W - 2;

  logic [OP_W-1:0]   op;
  logic [5:0]        fn;
  logic [4:0]        sh;
  logic [REG_AW-1:0] rt, rd;
  logic [IMM_W-1:0]  imm;

  assign op   = ir_i[31:26];
  assign rs_o = ir_i[25:21];
  assign rt   = ir_i[20:16];
  assign rd   = ir_i[15:11];
  assign sh   = ir_i[10:6];
  assign fn   = ir_i[5:0];
  assign imm  = ir_i[15:0];
  assign rt_o = rt;

  assign target_o = pc_i + PC_W'(4) + {{SEXT_W{imm[IMM_W-1]}}, imm, 2'b00};

  always_comb begin
    bundle_o            = '0;
    bundle_o.valid      = valid_i;
    bundle_o.ex.alu_op  = ALU_ADD;
    bundle_o.wb.dst     = (op == OP_RR) ? rd : rt;
    case (op)
      OP_RR: begin
        if (sh == 5'd0) begin
          case (fn)
            FN_ADD: begin
              bundle_o.ex.alu_op = ALU_ADD;
              bundle_o.ex.ovf_en = 1'b1;
              bundle_o.wb.en     = 1'b1;
            end
            FN_SUB: begin
              bundle_o.ex.alu_op = ALU_SUB;
              bundle_o.ex.ovf_en = 1'b1;
              bundle_o.wb.en     = 1'b1;
            end
            FN_AND: begin
              bundle_o.ex.alu_op = ALU_AND;
              bundle_o.wb.en     = 1'b1;
            end
            FN_OR: begin
              bundle_o.ex.alu_op = ALU_OR;
              bundle_o.wb.en     = 1'b1;
            end
            default: ;
          endcase
        end
      end
      OP_ADDI: begin
        bundle_o.ex.imm_sel = 1'b1;
        bundle_o.ex.ovf_en  = 1'b1;
        bundle_o.wb.en      = 1'b1;
      end
      OP_ORI: begin
        bundle_o.ex.alu_op   = ALU_OR;
        bundle_o.ex.imm_sel  = 1'b1;
        bundle_o.ex.imm_zext = 1'b1;
        bundle_o.wb.en       = 1'b1;
      end
      OP_LOAD: begin
        bundle_o.ex.imm_sel = 1'b1;
        bundle_o.mem.rd     = 1'b1;
        bundle_o.wb.en      = 1'b1;
      end
      OP_STORE: begin
        bundle_o.ex.imm_sel = 1'b1;
        bundle_o.mem.wr     = 1'b1;
      end
      OP_BEQ: begin
        bundle_o.ex.alu_op = ALU_SUB;
        bundle_o.ex.branch = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pcc_pipe.sv
module pcc_pipe
  import pcc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  ex_bundle_t      dec_i,
  input  logic [PC_W-1:0] target_i,
  input  logic            eq_i,
  output ex_bundle_t      ex_o,
  output mem_bundle_t     mem_o,
  output wb_bundle_t      wb_o,
  output logic            take_o,
  output logic [PC_W-1:0] target_o
);
  ex_bundle_t      ex_q;
  mem_bundle_t     mem_q;
  wb_bundle_t      wb_q;
  logic [PC_W-1:0] tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_q  <= '0;
      mem_q <= '0;
      wb_q  <= '0;
      tgt_q <= '0;
    end else begin
      ex_q       <= dec_i;
      tgt_q      <= target_i;
      mem_q.valid <= ex_q.valid;
      mem_q.mem   <= ex_q.mem;
      mem_q.wb    <= ex_q.wb;
      wb_q.valid  <= mem_q.valid;
      wb_q.wb     <= mem_q.wb;
    end
  end

  assign take_o   = ex_q.valid & ex_q.ex.branch & eq_i;
  assign target_o = tgt_q;
  assign ex_o     = ex_q;
  assign mem_o    = mem_q;
  assign wb_o     = wb_q;
endmodule

// File: rtl/dstat_pipe_ctrl.sv
module dstat_pipe_ctrl
  import pcc_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               eq_i,
  output logic [PC_W-1:0]    pc_o,
  output logic               pc_take_o,
  output logic [REG_AW-1:0]  rf_rs_o,
  output logic [REG_AW-1:0]  rf_rt_o,
  output logic               ex_valid_o,
  output logic [1:0]         ex_alu_op_o,
  output logic               ex_imm_sel_o,
  output logic               ex_imm_zext_o,
  output logic               ex_ovf_en_o,
  output logic               mem_read_o,
  output logic               mem_write_o,
  output logic               mem_pass_o,
  output logic               wb_en_o,
  output logic [REG_AW-1:0]  wb_dst_o
);
  logic [INSTR_W-1:0] ir;
  logic [PC_W-1:0]    dpc;
  logic               dvalid;
  logic               take;
  logic [PC_W-1:0]    ex_target;
  logic [PC_W-1:0]    dec_target;
  ex_bundle_t         dec_b;
  ex_bundle_t         ex_b;
  mem_bundle_t        mem_b;
  wb_bundle_t         wb_b;

  pcc_fetch #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .instr_i  (instr_i),
    .take_i   (take),
    .target_i (ex_target),
    .pc_o     (pc_o),
    .ir_o     (ir),
    .dpc_o    (dpc),
    .dvalid_o (dvalid)
  );

  pcc_decode #(.PC_W(PC_W)) u_decode (
    .ir_i     (ir),
    .pc_i     (dpc),
    .valid_i  (dvalid),
    .bundle_o (dec_b),
    .target_o (dec_target),
    .rs_o     (rf_rs_o),
    .rt_o     (rf_rt_o)
  );

  pcc_pipe #(.PC_W(PC_W)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .dec_i    (dec_b),
    .target_i (dec_target),
    .eq_i     (eq_i),
    .ex_o     (ex_b),
    .mem_o    (mem_b),
    .wb_o     (wb_b),
    .take_o   (take),
    .target_o (ex_target)
  );

  // every side effect is qualified by the stage's own valid bit
  assign pc_take_o     = take;
  assign ex_valid_o    = ex_b.valid;
  assign ex_alu_op_o   = ex_b.ex.alu_op;
  assign ex_imm_sel_o  = ex_b.ex.imm_sel;
  assign ex_imm_zext_o = ex_b.ex.imm_zext;
  assign ex_ovf_en_o   = ex_b.valid & ex_b.ex.ovf_en;
  assign mem_read_o    = mem_b.valid & mem_b.mem.rd;
  assign mem_write_o   = mem_b.valid & mem_b.mem.wr;
  assign mem_pass_o    = mem_b.valid & mem_b.wb.en & ~mem_b.mem.rd;
  assign wb_en_o       = wb_b.valid & wb_b.wb.en;
  assign wb_dst_o      = wb_b.wb.dst;
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] pc_o,
  input logic            pc_take_o,
  input logic            ex_valid_o,
  input logic            ex_ovf_en_o,
  input logic            mem_read_o,
  input logic            mem_write_o,
  input logic            mem_pass_o,
  input logic            wb_en_o
);
  assert_reset_empty_R1: assert property (@(posedge clk)
    $fell(rst) |-> (pc_o == RESET_PC && !ex_valid_o && !pc_take_o && !mem_read_o &&
                    !mem_write_o && !mem_pass_o && !wb_en_o));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pc_take_o)) |-> pc_o == $past(pc_o) + PC_W'(4));

  assert_take_live_R2: assert property (@(posedge clk) disable iff (rst)
    pc_take_o |-> ex_valid_o);

  assert_wb_source_R3: assert property (@(posedge clk) disable iff (rst)
    (wb_en_o && !$past(rst)) |-> $past(mem_pass_o || mem_read_o));

  assert_mem_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(mem_write_o && (mem_read_o || mem_pass_o)));

  assert_store_no_wb_R4: assert property (@(posedge clk) disable iff (rst)
    mem_write_o |=> !wb_en_o);

  assert_load_wb_R5: assert property (@(posedge clk) disable iff (rst)
    mem_read_o |=> wb_en_o);

  assert_pass_wb_R6: assert property (@(posedge clk) disable iff (rst)
    mem_pass_o |=> wb_en_o);

  assert_ovf_live_R7: assert property (@(posedge clk) disable iff (rst)
    ex_ovf_en_o |-> ex_valid_o);

  assert_shadow_killed_R8: assert property (@(posedge clk) disable iff (rst)
    pc_take_o |-> ##2 !ex_valid_o);
endmodule

bind dstat_pipe_ctrl pcc_checker #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pcc_checker (
  .clk         (clk),
  .rst         (rst),
  .pc_o        (pc_o),
  .pc_take_o   (pc_take_o),
  .ex_valid_o  (ex_valid_o),
  .ex_ovf_en_o (ex_ovf_en_o),
  .mem_read_o  (mem_read_o),
  .mem_write_o (mem_write_o),
  .mem_pass_o  (mem_pass_o),
  .wb_en_o     (wb_en_o)
);

// File: tb/test_dstat_pipe_ctrl.sv
module test_dstat_pipe_ctrl;
  localparam int PC_W = 32;

  typedef enum int {K_ADD, K_SUB, K_AND, K_OR, K_ADDI, K_ORI, K_LW, K_SW, K_BEQ, K_NOP} kind_e;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            eq  = 1'b0;
  logic [31:0]     instr;
  logic [PC_W-1:0] pc;
  logic            take, ex_valid, imm_sel, imm_zext, ovf, mrd, mwr, mpass, wb_en;
  logic [4:0]      rs, rt, wb_dst;
  logic [1:0]      alu_op;

  logic [31:0] prog [64];
  assign instr = prog[pc[7:2]];

  always #5 clk = ~clk;

  dstat_pipe_ctrl #(.PC_W(PC_W)) i_dstat_pipe_ctrl (
    .clk(clk), .rst(rst), .instr_i(instr), .eq_i(eq), .pc_o(pc), .pc_take_o(take),
    .rf_rs_o(rs), .rf_rt_o(rt), .ex_valid_o(ex_valid), .ex_alu_op_o(alu_op),
    .ex_imm_sel_o(imm_sel), .ex_imm_zext_o(imm_zext), .ex_ovf_en_o(ovf),
    .mem_read_o(mrd), .mem_write_o(mwr), .mem_pass_o(mpass), .wb_en_o(wb_en),
    .wb_dst_o(wb_dst)
  );

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // model of stage occupancy: 1 decode, 2 execute, 3 memory, 4 write-back
  logic            m_v  [1:4];
  logic            m_sq [1:4];
  logic [31:0]     m_w  [1:4];
  logic [PC_W-1:0] m_a  [1:4];
  logic [PC_W-1:0] f_pc;

  function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] d, logic [4:0] s, logic [4:0] t);
    return {6'h00, s, t, d, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] t, logic [4:0] s, logic [15:0] imm);
    return {op, s, t, imm};
  endfunction

  function automatic kind_e kind_of(logic [31:0] w);
    case (w[31:26])
      6'h00: begin
        if (w[10:6] != 5'd0) return K_NOP;
        case (w[5:0])
          6'h20: return K_ADD;
          6'h22: return K_SUB;
          6'h24: return K_AND;
          6'h25: return K_OR;
          default: return K_NOP;
        endcase
      end
      6'h08: return K_ADDI;
      6'h0D: return K_ORI;
      6'h23: return K_LW;
      6'h2B: return K_SW;
      6'h04: return K_BEQ;
      default: return K_NOP;
    endcase
  endfunction

  function automatic bit writes_reg(kind_e k);
    return k inside {K_ADD, K_SUB, K_AND, K_OR, K_ADDI, K_ORI, K_LW};
  endfunction

  function automatic logic [1:0] alu_exp(kind_e k);
    case (k)
      K_SUB, K_BEQ: return 2'd1;
      K_AND:        return 2'd2;
      K_OR, K_ORI:  return 2'd3;
      default:      return 2'd0;
    endcase
  endfunction

  function automatic logic [4:0] dst_exp(logic [31:0] w);
    return (w[31:26] == 6'h00) ? w[15:11] : w[20:16];
  endfunction

  function automatic logic [31:0] rand_instr();
    logic [4:0]  a = 5'($urandom);
    logic [4:0]  b = 5'($urandom);
    logic [4:0]  c = 5'($urandom);
    logic [15:0] imm = 16'($urandom);
    int sel = int'($urandom % 11);
    case (sel)
      0: return enc_r(6'h20, c, a, b);
      1: return enc_r(6'h22, c, a, b);
      2: return enc_r(6'h24, c, a, b);
      3: return enc_r(6'h25, c, a, b);
      4: return enc_i(6'h08, b, a, imm);
      5: return enc_i(6'h0D, b, a, imm);
      6: return enc_i(6'h23, b, a, imm);
      7: return enc_i(6'h2B, b, a, imm);
      8: return enc_i(6'h04, b, a, 16'(int'($urandom % 13) - 6));
      9: return {6'h00, a, b, c, 5'd3, 6'h20};
      default: return {6'h3F, a, b, imm};
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    f_pc = '0;
    for (int i = 1; i <= 4; i++) begin
      m_v[i] = 1'b0; m_sq[i] = 1'b0; m_w[i] = '0; m_a[i] = '0;
    end
  endtask

  task automatic step(input bit rnd_eq);
    kind_e k2, k3, k4;
    logic taken;
    logic [PC_W-1:0] tgt;
    eq = rnd_eq ? 1'($urandom) : 1'b1;
    #1;
    k2 = kind_of(m_w[2]);
    k3 = kind_of(m_w[3]);
    k4 = kind_of(m_w[4]);
    taken = m_v[2] && (k2 == K_BEQ) && eq;
    chk("R2", "pc_o", pc, f_pc);
    chk("R2", "pc_take_o", take, taken);
    chk("R10", "rf_rs_o", rs, m_w[1][25:21]);
    chk("R10", "rf_rt_o", rt, m_w[1][20:16]);
    chk(m_sq[2] ? "R8" : "R7", "ex_valid_o", ex_valid, m_v[2]);
    if (m_v[2] && k2 != K_NOP) begin
      chk("R7", "ex_alu_op_o", alu_op, alu_exp(k2));
      chk("R7", "ex_imm_sel_o", imm_sel, k2 inside {K_ADDI, K_ORI, K_LW, K_SW});
      chk("R7", "ex_imm_zext_o", imm_zext, k2 == K_ORI);
    end
    chk(m_sq[2] ? "R8" : "R7", "ex_ovf_en_o", ovf, m_v[2] && (k2 inside {K_ADD, K_SUB, K_ADDI}));
    chk(m_sq[3] ? "R8" : "R5", "mem_read_o", mrd, m_v[3] && k3 == K_LW);
    chk(m_sq[3] ? "R8" : "R4", "mem_write_o", mwr, m_v[3] && k3 == K_SW);
    chk(m_sq[3] ? "R8" : (k3 inside {K_BEQ, K_NOP}) ? "R9" : "R6", "mem_pass_o", mpass,
        m_v[3] && writes_reg(k3) && k3 != K_LW);
    chk(m_sq[4] ? "R8" : (k4 inside {K_BEQ, K_NOP}) ? "R9" : "R3", "wb_en_o", wb_en,
        m_v[4] && writes_reg(k4));
    if (m_v[4] && writes_reg(k4)) chk("R3", "wb_dst_o", wb_dst, dst_exp(m_w[4]));
    tgt = m_a[2] + PC_W'(4) + {{(PC_W-18){m_w[2][15]}}, m_w[2][15:0], 2'b00};
    for (int i = 4; i >= 2; i--) begin
      m_v[i] = m_v[i-1]; m_sq[i] = m_sq[i-1]; m_w[i] = m_w[i-1]; m_a[i] = m_a[i-1];
    end
    m_v[1]  = !taken;
    m_sq[1] = taken;
    m_w[1]  = prog[f_pc[7:2]];
    m_a[1]  = f_pc;
    f_pc    = taken ? tgt : f_pc + PC_W'(4);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    eq  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    #1;
    chk("R1", "pc_o after reset", pc, '0);
    chk("R1", "ex_valid_o after reset", ex_valid, 1'b0);
    chk("R1", "pc_take_o after reset", take, 1'b0);
    chk("R1", "mem_read_o after reset", mrd, 1'b0);
    chk("R1", "mem_write_o after reset", mwr, 1'b0);
    chk("R1", "mem_pass_o after reset", mpass, 1'b0);
    chk("R1", "wb_en_o after reset", wb_en, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 64; i++) prog[i] = rand_instr();
    // directed: delay slot at 16 completes, 20 is squashed, target 36
    prog[0]  = enc_i(6'h08, 5'd2, 5'd2, 16'd3);
    prog[1]  = enc_i(6'h23, 5'd1, 5'd2, 16'd35);
    prog[2]  = enc_r(6'h22, 5'd3, 5'd4, 5'd5);
    prog[3]  = enc_i(6'h04, 5'd7, 5'd6, 16'd5);
    prog[4]  = enc_i(6'h0D, 5'd8, 5'd9, 16'd17);
    prog[5]  = enc_r(6'h20, 5'd10, 5'd11, 5'd12);
    prog[6]  = enc_i(6'h2B, 5'd3, 5'd2, 16'd8);
    prog[7]  = {6'h00, 5'd1, 5'd2, 5'd3, 5'd1, 6'h20};
    prog[8]  = {6'h3F, 26'd0};
    prog[9]  = enc_r(6'h24, 5'd13, 5'd14, 5'd15);
    prog[10] = enc_i(6'h2B, 5'd13, 5'd0, 16'd4);
    prog[11] = enc_i(6'h04, 5'd1, 5'd1, 16'hFFF4);
    // branch sitting in another branch's delay slot
    prog[12] = enc_i(6'h04, 5'd1, 5'd1, 16'd2);
    prog[13] = enc_i(6'h04, 5'd2, 5'd2, 16'd4);
    do_reset();
    for (int i = 0; i < 40; i++) step(1'b0);
    for (int i = 0; i < 3000; i++) step(1'b1);
    do_reset();
    for (int i = 0; i < 400; i++) step(1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule